// File: doc/BRIEF.md
# Local Bus Interrupt Collector

This block gathers sixteen level-sensitive interrupt lines from a local peripheral bus into a single request toward the processor's interrupt logic. Each line is captured every clock into a source register, so a source bit is set while its line is high and clears as soon as the line drops. A software-owned enable mask selects which sources may raise the combined request output.

Software reaches the block through a small 16-bit register port. One offset holds the enable mask, which can be read and written. The other offset is read-only and returns an encoded vector for the pending, enabled line with the lowest number, so a handler can dispatch without scanning a bitmap. Reading the vector changes nothing. The register port has no handshake: a read request is answered on the next clock and a write takes effect on the clock edge where it is presented.

Top module: `lbus_irq_collect`

## Requirements
- R1: Source bit i is loaded from line i on every clock, one cycle after the line is sampled: high sets it and low clears it.
- R2: `irq_req` is high exactly when at least one source bit is set and the matching mask bit is also set. It follows any change to a line or to the mask within one clock.
- R3: A read at byte offset 0x0 returns `(i + 1) * 4`, where i is the lowest-numbered line that is both pending and enabled. Pending lines whose mask bit is clear are skipped.
- R4: A read at byte offset 0x0 returns 0 when no enabled line is pending.
- R5: After reset the mask holds 0x0010, which enables line 4 only, and every source bit is clear.
- R6: A write at byte offset 0x2 replaces the whole 16-bit mask. A read at 0x2 returns the current mask.
- R7: Reading the vector has no side effect. Repeated reads return the same value, and `irq_req` is unchanged.
- R8: All accesses are 16 bits wide. A read at any other offset returns 0, and this includes odd offsets. A write at any other offset is ignored, and so is a write to offset 0x0.
- R9: Read data appears on `rd_data` on the clock after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | 16 | Level-sensitive interrupt inputs, one per line |
| bus_addr | input | 4 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe for one clock |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe for one clock |
| rd_data | output | 16 | Read data, registered |
| irq_req | output | 1 | Combined request, high while any enabled source is pending |

## Verification
The hardest case is a vector read in which the lowest pending line is masked off and a higher line is enabled. A priority encoder that looks at the raw sources would return the wrong line here, while `irq_req` would still be correct. The stimulus first writes a mask that skips the low lines. It then raises a mix of masked and enabled lines, reads the vector, drops the enabled winner and reads again. It also checks that a pending line that is entirely masked reads as 0 with `irq_req` low.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
  localparam int LBIC_REG_W = 16;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } lbic_sel_e;
endpackage

// File: rtl/lbic_src_reg.sv
module lbic_src_reg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] src_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) src_o[g] <= 1'b0;
      else        src_o[g] <= lines_i[g];
    end
  end
endmodule

// File: rtl/lbic_mask_reg.sv
module lbic_mask_reg #(
  parameter int           N   = 16,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_o <= RST;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/lbic_prio_enc.sv
module lbic_prio_enc #(
  parameter int N     = 16,
  parameter int VEC_W = 16
) (
  input  logic [N-1:0]     pend_i,
  output logic [VEC_W-1:0] vec_o
);
  // Scan from the top down so that the lowest set index wins last.
  always_comb begin
    vec_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) vec_o = VEC_W'((k + 1) * 4);
    end
  end
endmodule

// File: rtl/lbus_irq_collect.sv
module lbus_irq_collect #(
  parameter int          NUM_LINES = 16,
  parameter int          ADDR_W    = 4,
  parameter int          VEC_OFS   = 0,
  parameter int          MASK_OFS  = 2,
  parameter logic [15:0] MASK_RST  = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 wr_en,
  input  logic [15:0]          wr_data,
  input  logic                 rd_en,
  output logic [15:0]          rd_data,
  output logic                 irq_req
);
  import lbic_pkg::*;

  localparam int REG_W = LBIC_REG_W;
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);

  logic [NUM_LINES-1:0] src_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend;
  logic [REG_W-1:0]     vec;
  logic [REG_W-1:0]     rd_mux;
  lbic_sel_e            sel;

  always_comb begin
    if (bus_addr == A_VEC)       sel = SEL_VEC;
    else if (bus_addr == A_MASK) sel = SEL_MASK;
    else                         sel = SEL_NONE;
  end

  lbic_src_reg #(.N(NUM_LINES)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (irq_lines),
    .src_o   (src_q)
  );

  lbic_mask_reg #(.N(NUM_LINES), .RST(MASK_RST[NUM_LINES-1:0])) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en && sel == SEL_MASK),
    .wdata_i (wr_data[NUM_LINES-1:0]),
    .mask_o  (mask_q)
  );

  assign pend = src_q & mask_q;

  lbic_prio_enc #(.N(NUM_LINES), .VEC_W(REG_W)) u_enc (
    .pend_i (pend),
    .vec_o  (vec)
  );

  assign irq_req = |pend;

  always_comb begin
    case (sel)
      SEL_VEC:  rd_mux = vec;
      SEL_MASK: rd_mux = REG_W'(mask_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/lbus_irq_collect_chk.sv
module lbus_irq_collect_chk #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [15:0]          rd_data,
  input logic                 irq_req,
  input logic [NUM_LINES-1:0] src_q,
  input logic [NUM_LINES-1:0] mask_q
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  logic unmapped;
  assign unmapped = (bus_addr != ADDR_W'(0)) && (bus_addr != ADDR_W'(2));

  a_r1_src_follows: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    src_q == $past(irq_lines));

  a_r5_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == NUM_LINES'(16'h0010) && src_q == '0));

  a_r4_vec_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == ADDR_W'(0)) |=> ((rd_data == 16'h0) == !$past(irq_req)));

  a_r3_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == ADDR_W'(0)) |=> (rd_data[1:0] == 2'b00));

  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == 16'h0));

  a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr != ADDR_W'(2)) |=> $stable(mask_q));

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

bind lbus_irq_collect lbus_irq_collect_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lines (irq_lines),
  .bus_addr  (bus_addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .irq_req   (irq_req),
  .src_q     (src_q),
  .mask_q    (mask_q)
);

// File: tb/test_lbus_irq_collect.sv
module test_lbus_irq_collect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [3:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        irq_req;

  int total = 0;
  int bad = 0;
  logic [15:0] mask_m = 16'h0010;

  always #10 clk = ~clk;

  lbus_irq_collect i_lbus_irq_collect (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_req(irq_req)
  );

  function automatic logic [15:0] exp_vec(logic [15:0] l, logic [15:0] m);
    for (int k = 0; k < 16; k++) if (l[k] && m[k]) return 16'((k + 1) * 4);
    return 16'h0;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_write(logic [3:0] a, logic [15:0] v);
    @(negedge clk); bus_addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    if (a == 4'h2) mask_m = v;
  endtask

  task automatic set_lines(logic [15:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R5 irq after reset", {15'b0, irq_req}, 16'h0);
    do_read(4'h2, d); chk("R5 mask reset", d, 16'h0010);
    do_read(4'h0, d); chk("R5 vec reset", d, 16'h0);
  endtask

  task automatic t_single;
    logic [15:0] d;
    set_lines(16'h0010);
    chk("R2 irq line4", {15'b0, irq_req}, 16'h1);
    do_read(4'h0, d); chk("R3 vec line4", d, 16'd20);
    set_lines(16'h0000);
    chk("R1 line drop clears", {15'b0, irq_req}, 16'h0);
    do_read(4'h0, d); chk("R4 vec idle", d, 16'h0);
  endtask

  task automatic t_masked_only;
    logic [15:0] d;
    set_lines(16'h0003);
    chk("R2 masked irq low", {15'b0, irq_req}, 16'h0);
    do_read(4'h0, d); chk("R4 masked vec zero", d, exp_vec(16'h0003, mask_m));
    set_lines(16'h0);
  endtask

  task automatic t_priority;
    logic [15:0] d;
    do_write(4'h2, 16'hA0C0);
    do_read(4'h2, d); chk("R6 mask readback", d, 16'hA0C0);
    set_lines(16'h80F3);
    do_read(4'h0, d); chk("R3 skip masked low lines", d, exp_vec(16'h80F3, mask_m));
    set_lines(16'h80B3);
    do_read(4'h0, d); chk("R3 next winner", d, exp_vec(16'h80B3, mask_m));
    set_lines(16'h8000);
    do_read(4'h0, d); chk("R3 line15 vector", d, 16'd64);
    set_lines(16'h0);
  endtask

  task automatic t_irq_follows_mask;
    set_lines(16'h0001);
    do_write(4'h2, 16'h0001);
    chk("R2 irq after mask set", {15'b0, irq_req}, 16'h1);
    do_write(4'h2, 16'h0000);
    chk("R2 irq after mask clear", {15'b0, irq_req}, 16'h0);
    do_write(4'h2, 16'hFFFF);
  endtask

  task automatic t_no_side_effect;
    logic [15:0] d1, d2;
    do_read(4'h0, d1);
    chk("R3 line0 vector", d1, 16'd4);
    do_read(4'h0, d2);
    chk("R7 repeat read same", d2, d1);
    chk("R7 irq still high", {15'b0, irq_req}, 16'h1);
    @(negedge clk); @(negedge clk);
    chk("R9 rdata holds", rd_data, d1);
    set_lines(16'h0);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    set_lines(16'h0004);
    do_read(4'h1, d); chk("R8 odd offset reads zero", d, 16'h0);
    do_read(4'h6, d); chk("R8 unmapped read zero", d, 16'h0);
    @(negedge clk); bus_addr = 4'h6; wr_data = 16'h0000; wr_en = 1'b1;
    @(negedge clk); bus_addr = 4'h0; wr_data = 16'h0000;
    @(negedge clk); bus_addr = 4'h3; wr_data = 16'h0000;
    @(negedge clk); wr_en = 1'b0;
    do_read(4'h2, d); chk("R8 ignored writes keep mask", d, mask_m);
    chk("R8 irq unchanged", {15'b0, irq_req}, 16'h1);
    set_lines(16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_masked_only();
    t_priority();
    t_irq_follows_mask();
    t_no_side_effect();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule